// File: doc/BRIEF.md
# Multi-drop UART Receiver with Standby Wakeup

This block receives asynchronous serial frames on one line that several receivers share. Each frame is one start bit, eight data bits sent least significant bit first, and one stop bit. The line is sampled by a 16x oversampling tick. At the start of each message, software reads the addressing bytes. When a message is meant for another node, software pulses a standby request. The receiver then stays quiet until a wakeup event marks the start of the next message.

Two wakeup methods are available, chosen by a select input. In line-idle mode, a full idle character ends standby. That character raises neither the data-ready flag nor the idle flag. In address-mark mode, a frame whose most significant bit is 1 ends standby as soon as that bit is sampled. The frame then completes normally and raises data-ready, so software can read the address byte. A second select input sets where idle counting begins: either right after the start bit, or only after the stop bit.

Top module: `uart_wake_rx`

## Requirements
- R1: A frame on `rxd_i` (low start bit, eight data bits LSB first, stop bit) is sampled at bit centres. Once the stop bit centre has passed, `rx_data_o` holds the byte and `rdf_o` is 1.
- R2: A low pulse on the line that lasts less than half a bit time starts no frame and sets no flag. A real frame sent after it is received correctly.
- R3: A one-cycle `data_rd_i` pulse clears `rdf_o` and `idle_flag_o` on the next clock.
- R4: A one-cycle `standby_set_i` pulse makes `standby_o` 1 on the next clock.
- R5: While `standby_o` is 1, a frame that does not meet the wakeup rule leaves `rdf_o` at 0 and leaves `rx_data_o` unchanged.
- R6: With `wake_sel_i` = 0, ten bit times of logic 1 on the line clear `standby_o`. Neither `idle_flag_o` nor `rdf_o` is set by that idle character.
- R7: With `wake_sel_i` = 1, a frame received in standby whose bit 7 is 1 clears `standby_o` before its stop bit is sampled. When the frame completes, `rdf_o` is 1 and `rx_data_o` holds the byte.
- R8: With `wake_sel_i` = 1 and `standby_o` = 1, frames with bit 7 = 0 and idle characters both leave `standby_o` at 1.
- R9: Outside standby, the first idle character after an accepted frame sets `idle_flag_o`. It is not set again until another frame has been accepted. Idle time with no frame before it never sets the flag.
- R10: With `idle_type_i` = 0, idle counting starts after the start bit, so 1-valued data bits count. With `idle_type_i` = 1, counting starts only after the stop bit. After a 0xFF frame, the flag therefore rises about nine bit times sooner with `idle_type_i` = 0.
- R11: With `wake_sel_i` = 0, if standby is requested after the line has already been idle for a full character, `standby_o` is 1 for exactly one cycle and then returns to 0.
- R12: After reset, `rdf_o`, `idle_flag_o` and `standby_o` are 0 and `rx_data_o` is 0x00.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| os_tick_i | input | 1 | One-cycle pulse at 16 times the bit rate |
| rxd_i | input | 1 | Serial line, idle high |
| wake_sel_i | input | 1 | 0: line-idle wakeup, 1: address-mark wakeup |
| idle_type_i | input | 1 | 0: idle count begins after start bit, 1: after stop bit |
| standby_set_i | input | 1 | One-cycle pulse that enters standby |
| data_rd_i | input | 1 | One-cycle read strobe that clears the receive flags |
| rx_data_o | output | 8 | Last accepted byte |
| rdf_o | output | 1 | Receive data full |
| idle_flag_o | output | 1 | Idle line seen after accepted data |
| standby_o | output | 1 | Receiver is in standby |

## Verification
The hardest case to reach is standby that starts while the idle counter is at a chosen point. It has to be partway for the line-idle wakeup and already saturated for the immediate-wake corner. The stimulus controls this through timing alone. It sends a frame and pulses standby within half a bit time of the frame's end, with counting set to begin after the stop bit, so the counter is known to be small. For the corner case, it holds the line high for twelve bit times before the request. The address-mark case samples the ports at the boundary between the last data bit and the stop bit, which shows that standby clears before the frame completes.

// File: rtl/uwr_pkg.sv
// Shared types for the standby-wakeup UART receiver.
package uwr_pkg;
    // Phases of the frame sampler.
    typedef enum logic [1:0] {
        FR_IDLE  = 2'd0,
        FR_START = 2'd1,
        FR_DATA  = 2'd2,
        FR_STOP  = 2'd3
    } fr_state_e;
endpackage

// File: rtl/uwr_sync.sv
// Multi-stage synchronizer for the asynchronous serial line.
// Assumes the line idles at RST_VAL so no false start appears out of reset.
module uwr_sync #(
    parameter int   STAGES  = 2,
    parameter logic RST_VAL = 1'b1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic d_i,
    output logic q_o
);
    logic [STAGES-1:0] chain_q;

    // Shift the raw line through the flop chain.
    always_ff @(posedge clk) begin
        if (!rst_n) chain_q <= {STAGES{RST_VAL}};
        else        chain_q <= {chain_q[STAGES-2:0], d_i};
    end

    assign q_o = chain_q[STAGES-1];
endmodule

// File: rtl/uwr_framer.sv
// Frame sampler: finds a start edge, confirms it at half a bit, then samples
// each data bit and the stop bit at their centres. Data arrives LSB first.
// Assumes tick_i pulses OVS times per bit. The stop bit value is not checked.
// Outputs are one-cycle pulses: msb_o when the last data bit was 1,
// done_o when the stop bit centre is reached.
module uwr_framer
    import uwr_pkg::*;
#(
    parameter int OVS       = 16,
    parameter int DATA_BITS = 8
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 tick_i,
    input  logic                 rx_i,
    output logic                 busy_o,
    output logic                 done_o,
    output logic                 msb_o,
    output logic [DATA_BITS-1:0] data_o
);
    localparam int CW = $clog2(OVS);
    localparam int IW = (DATA_BITS > 1) ? $clog2(DATA_BITS) : 1;
    localparam logic [CW-1:0] HALF_CNT = CW'(OVS / 2 - 1);
    localparam logic [CW-1:0] LAST_CNT = CW'(OVS - 1);
    localparam logic [IW-1:0] TOP_IDX  = IW'(DATA_BITS - 1);

    fr_state_e            state_q;
    logic [CW-1:0]        cnt_q;
    logic [IW-1:0]        idx_q;
    logic [DATA_BITS-1:0] shreg_q;

    // Sampling state machine, advanced only on oversampling ticks.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= FR_IDLE;
            cnt_q   <= '0;
            idx_q   <= '0;
            shreg_q <= '0;
            done_o  <= 1'b0;
            msb_o   <= 1'b0;
        end else begin
            done_o <= 1'b0;
            msb_o  <= 1'b0;
            if (tick_i) begin
                unique case (state_q)
                    FR_IDLE: begin
                        if (!rx_i) begin
                            state_q <= FR_START;
                            cnt_q   <= '0;
                        end
                    end
                    FR_START: begin
                        if (cnt_q == HALF_CNT) begin
                            cnt_q   <= '0;
                            idx_q   <= '0;
                            state_q <= rx_i ? FR_IDLE : FR_DATA;
                        end else begin
                            cnt_q <= cnt_q + 1'b1;
                        end
                    end
                    FR_DATA: begin
                        if (cnt_q == LAST_CNT) begin
                            cnt_q   <= '0;
                            shreg_q <= {rx_i, shreg_q[DATA_BITS-1:1]};
                            if (idx_q == TOP_IDX) begin
                                state_q <= FR_STOP;
                                msb_o   <= rx_i;
                            end else begin
                                idx_q <= idx_q + 1'b1;
                            end
                        end else begin
                            cnt_q <= cnt_q + 1'b1;
                        end
                    end
                    FR_STOP: begin
                        if (cnt_q == LAST_CNT) begin
                            cnt_q   <= '0;
                            state_q <= FR_IDLE;
                            done_o  <= 1'b1;
                        end else begin
                            cnt_q <= cnt_q + 1'b1;
                        end
                    end
                    default: state_q <= FR_IDLE;
                endcase
            end
        end
    end

    assign busy_o = (state_q != FR_IDLE);
    assign data_o = shreg_q;
endmodule

// File: rtl/uwr_idle_det.sv
// Idle-line detector: counts oversampling ticks with the line at 1 and
// saturates at one idle character (IDLE_BITS bit times).
// A low line clears the count. When start_after_stop_i is set, the count is
// also held at zero while a frame is in progress.
// idle_pulse_o fires once when the count saturates; idle_full_o is a level.
module uwr_idle_det #(
    parameter int OVS       = 16,
    parameter int IDLE_BITS = 10
) (
    input  logic clk,
    input  logic rst_n,
    input  logic tick_i,
    input  logic rx_i,
    input  logic busy_i,
    input  logic start_after_stop_i,
    output logic idle_pulse_o,
    output logic idle_full_o
);
    localparam int MAXC = OVS * IDLE_BITS;
    localparam int CW   = $clog2(MAXC + 1);
    localparam logic [CW-1:0] FULL_CNT = CW'(MAXC);
    localparam logic [CW-1:0] NEAR_CNT = CW'(MAXC - 1);

    logic [CW-1:0] cnt_q;
    logic          hold;

    assign hold = !rx_i || (start_after_stop_i && busy_i);

    // Count idle ticks and flag the saturating step.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q        <= '0;
            idle_pulse_o <= 1'b0;
        end else begin
            idle_pulse_o <= 1'b0;
            if (hold) begin
                cnt_q <= '0;
            end else if (tick_i && (cnt_q != FULL_CNT)) begin
                cnt_q        <= cnt_q + 1'b1;
                idle_pulse_o <= (cnt_q == NEAR_CNT);
            end
        end
    end

    assign idle_full_o = (cnt_q == FULL_CNT);
endmodule

// File: rtl/uwr_standby_ctl.sv
// Standby and flag control. Keeps the standby bit, the receive-data-full flag,
// the idle flag and the data register.
// Assumes the event inputs are one-cycle pulses from the framer and the idle
// detector. Line-idle wakeup uses the idle level, so a receiver that enters
// standby on an already idle line wakes on the following clock.
module uwr_standby_ctl #(
    parameter int DATA_BITS = 8
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 wake_sel_i,
    input  logic                 standby_set_i,
    input  logic                 data_rd_i,
    input  logic                 frame_done_i,
    input  logic [DATA_BITS-1:0] frame_data_i,
    input  logic                 msb_seen_i,
    input  logic                 idle_pulse_i,
    input  logic                 idle_full_i,
    output logic                 standby_o,
    output logic                 rdf_o,
    output logic                 idle_flag_o,
    output logic [DATA_BITS-1:0] data_o
);
    logic standby_q;
    logic armed_q;
    logic accept;
    logic wake_idle;
    logic wake_addr;

    assign accept    = frame_done_i && !standby_q;
    assign wake_idle = standby_q && !wake_sel_i && idle_full_i;
    assign wake_addr = standby_q &&  wake_sel_i && msb_seen_i;

    // Standby bit: software sets it, the selected wakeup event clears it.
    always_ff @(posedge clk) begin
        if (!rst_n)                       standby_q <= 1'b0;
        else if (standby_set_i)           standby_q <= 1'b1;
        else if (wake_idle || wake_addr)  standby_q <= 1'b0;
    end

    // Receive-data-full flag: set by an accepted frame, cleared by a read.
    always_ff @(posedge clk) begin
        if (!rst_n)          rdf_o <= 1'b0;
        else if (accept)     rdf_o <= 1'b1;
        else if (data_rd_i)  rdf_o <= 1'b0;
    end

    // Data register: loaded only by accepted frames.
    always_ff @(posedge clk) begin
        if (!rst_n)      data_o <= '0;
        else if (accept) data_o <= frame_data_i;
    end

    // Armed bit: allows one idle flag per accepted frame.
    always_ff @(posedge clk) begin
        if (!rst_n)            armed_q <= 1'b0;
        else if (accept)       armed_q <= 1'b1;
        else if (idle_pulse_i) armed_q <= 1'b0;
    end

    // Idle flag: set on an armed idle character outside standby, cleared by a read.
    always_ff @(posedge clk) begin
        if (!rst_n)                                       idle_flag_o <= 1'b0;
        else if (idle_pulse_i && armed_q && !standby_q)   idle_flag_o <= 1'b1;
        else if (data_rd_i)                               idle_flag_o <= 1'b0;
    end

    assign standby_o = standby_q;
endmodule

// File: rtl/uart_wake_rx.sv
// Top of the multi-drop UART receiver with standby wakeup.
// Assumes os_tick_i pulses OVS times per bit and rxd_i idles high.
// Chain: synchronizer -> frame sampler and idle detector -> standby control.
module uart_wake_rx #(
    parameter int OVS         = 16,
    parameter int DATA_BITS   = 8,
    parameter int IDLE_BITS   = 10,
    parameter int SYNC_STAGES = 2
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 os_tick_i,
    input  logic                 rxd_i,
    input  logic                 wake_sel_i,
    input  logic                 idle_type_i,
    input  logic                 standby_set_i,
    input  logic                 data_rd_i,
    output logic [DATA_BITS-1:0] rx_data_o,
    output logic                 rdf_o,
    output logic                 idle_flag_o,
    output logic                 standby_o
);
    logic                 rx_s;
    logic                 busy;
    logic                 frm_done;
    logic                 msb_seen;
    logic [DATA_BITS-1:0] frm_data;
    logic                 idle_pulse;
    logic                 idle_full;

    uwr_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) sync_i (
        .clk   (clk),
        .rst_n (rst_n),
        .d_i   (rxd_i),
        .q_o   (rx_s)
    );

    uwr_framer #(.OVS(OVS), .DATA_BITS(DATA_BITS)) framer_i (
        .clk    (clk),
        .rst_n  (rst_n),
        .tick_i (os_tick_i),
        .rx_i   (rx_s),
        .busy_o (busy),
        .done_o (frm_done),
        .msb_o  (msb_seen),
        .data_o (frm_data)
    );

    uwr_idle_det #(.OVS(OVS), .IDLE_BITS(IDLE_BITS)) idle_i (
        .clk                (clk),
        .rst_n              (rst_n),
        .tick_i             (os_tick_i),
        .rx_i               (rx_s),
        .busy_i             (busy),
        .start_after_stop_i (idle_type_i),
        .idle_pulse_o       (idle_pulse),
        .idle_full_o        (idle_full)
    );

    uwr_standby_ctl #(.DATA_BITS(DATA_BITS)) ctl_i (
        .clk           (clk),
        .rst_n         (rst_n),
        .wake_sel_i    (wake_sel_i),
        .standby_set_i (standby_set_i),
        .data_rd_i     (data_rd_i),
        .frame_done_i  (frm_done),
        .frame_data_i  (frm_data),
        .msb_seen_i    (msb_seen),
        .idle_pulse_i  (idle_pulse),
        .idle_full_i   (idle_full),
        .standby_o     (standby_o),
        .rdf_o         (rdf_o),
        .idle_flag_o   (idle_flag_o),
        .data_o        (rx_data_o)
    );
endmodule

// File: rtl/uwr_checker.sv
// Property checker for uart_wake_rx, attached through bind.
// It sees the ports and the internal event pulses of the top.
module uwr_checker #(
    parameter int DATA_BITS = 8
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic                 data_rd_i,
    input logic                 standby_set_i,
    input logic                 wake_sel_i,
    input logic                 rdf_o,
    input logic                 idle_flag_o,
    input logic                 standby_o,
    input logic [DATA_BITS-1:0] rx_data_o,
    input logic                 frm_done,
    input logic                 msb_seen,
    input logic                 idle_full
);
    AST_RDF_ONLY_AWAKE: assert property (@(posedge clk) disable iff (!rst_n)
        (rdf_o && !$past(rdf_o)) |-> !$past(standby_o)); // R5

    AST_IDLE_FLAG_AWAKE: assert property (@(posedge clk) disable iff (!rst_n)
        (idle_flag_o && !$past(idle_flag_o)) |-> !$past(standby_o)); // R6

    AST_READ_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        (data_rd_i && !frm_done) |=> !rdf_o); // R3

    AST_STANDBY_ENTRY: assert property (@(posedge clk) disable iff (!rst_n)
        standby_set_i |=> standby_o); // R4

    AST_ADDR_WAKE: assert property (@(posedge clk) disable iff (!rst_n)
        (standby_o && wake_sel_i && msb_seen && !standby_set_i) |=> !standby_o); // R7

    AST_IDLE_WAKE: assert property (@(posedge clk) disable iff (!rst_n)
        (standby_o && !wake_sel_i && idle_full && !standby_set_i) |=> !standby_o); // R11

    AST_DATA_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !frm_done |=> $stable(rx_data_o)); // R5
endmodule

bind uart_wake_rx uwr_checker #(.DATA_BITS(DATA_BITS)) chk_i (
    .clk           (clk),
    .rst_n         (rst_n),
    .data_rd_i     (data_rd_i),
    .standby_set_i (standby_set_i),
    .wake_sel_i    (wake_sel_i),
    .rdf_o         (rdf_o),
    .idle_flag_o   (idle_flag_o),
    .standby_o     (standby_o),
    .rx_data_o     (rx_data_o),
    .frm_done      (frm_done),
    .msb_seen      (msb_seen),
    .idle_full     (idle_full)
);

// File: tb/uart_wake_rx_tb_top.sv
// Directed bench: one task per scenario, each checking its own results.
module uart_wake_rx_tb_top;
    localparam int TICK_DIV = 4;
    localparam int BIT_CYC  = 16 * TICK_DIV;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       tick = 1'b0;
    logic       rxd = 1'b1;
    logic       wake_sel = 1'b0;
    logic       idle_type = 1'b1;
    logic       sb_set = 1'b0;
    logic       rd = 1'b0;
    logic [7:0] rx_data;
    logic       rdf;
    logic       idle_flag;
    logic       standby;

    int   total = 0;
    int   bad = 0;
    bit   fin = 1'b0;
    logic pre_sb;
    logic pre_rdf;

    always #4 clk = ~clk;

    uart_wake_rx dut_i (
        .clk           (clk),
        .rst_n         (rst_n),
        .os_tick_i     (tick),
        .rxd_i         (rxd),
        .wake_sel_i    (wake_sel),
        .idle_type_i   (idle_type),
        .standby_set_i (sb_set),
        .data_rd_i     (rd),
        .rx_data_o     (rx_data),
        .rdf_o         (rdf),
        .idle_flag_o   (idle_flag),
        .standby_o     (standby)
    );

    // Oversampling tick: one cycle high out of TICK_DIV.
    initial begin
        forever begin
            repeat (TICK_DIV - 1) @(negedge clk);
            tick = 1'b1;
            @(negedge clk);
            tick = 1'b0;
        end
    end

    task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic wait_cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic idle_bits(input int n);
        rxd = 1'b1;
        wait_cyc(n * BIT_CYC);
    endtask

    task automatic send_byte(input logic [7:0] b);
        @(negedge clk);
        rxd = 1'b0;
        wait_cyc(BIT_CYC);
        for (int i = 0; i < 8; i++) begin
            rxd = b[i];
            wait_cyc(BIT_CYC);
        end
        pre_sb  = standby;
        pre_rdf = rdf;
        rxd = 1'b1;
        wait_cyc(BIT_CYC);
    endtask

    task automatic pulse_rd;
        @(negedge clk);
        rd = 1'b1;
        @(negedge clk);
        rd = 1'b0;
    endtask

    task automatic pulse_sb;
        @(negedge clk);
        sb_set = 1'b1;
        @(negedge clk);
        sb_set = 1'b0;
    endtask

    task automatic t_reset;
        wait_cyc(4);
        rst_n = 1'b1;
        wait_cyc(2);
        chk(rdf == 1'b0, "R12 rdf", 32'(rdf), 0);
        chk(idle_flag == 1'b0, "R12 idle", 32'(idle_flag), 0);
        chk(standby == 1'b0, "R12 standby", 32'(standby), 0);
        chk(rx_data == 8'h00, "R12 data", 32'(rx_data), 0);
        idle_bits(12);
        chk(idle_flag == 1'b0, "R9 no frame no idle flag", 32'(idle_flag), 0);
    endtask

    task automatic t_basic;
        wake_sel = 1'b0;
        idle_type = 1'b1;
        send_byte(8'h5A);
        chk(rdf == 1'b1, "R1 rdf set", 32'(rdf), 1);
        chk(rx_data == 8'h5A, "R1 data", 32'(rx_data), 32'h5A);
        pulse_rd;
        chk(rdf == 1'b0, "R3 read clears rdf", 32'(rdf), 0);
        send_byte(8'h81);
        chk(rx_data == 8'h81, "R1 data lsb first", 32'(rx_data), 32'h81);
        pulse_rd;
        idle_bits(12);
        pulse_rd;
    endtask

    task automatic t_glitch;
        @(negedge clk);
        rxd = 1'b0;
        wait_cyc(12);
        rxd = 1'b1;
        idle_bits(3);
        chk(rdf == 1'b0, "R2 glitch no frame", 32'(rdf), 0);
        send_byte(8'hC3);
        chk(rx_data == 8'hC3, "R2 frame after glitch", 32'(rx_data), 32'hC3);
        pulse_rd;
        idle_bits(12);
        pulse_rd;
    endtask

    task automatic t_idle_flag;
        idle_type = 1'b1;
        send_byte(8'h3C);
        pulse_rd;
        idle_bits(12);
        chk(idle_flag == 1'b1, "R9 idle after frame", 32'(idle_flag), 1);
        pulse_rd;
        chk(idle_flag == 1'b0, "R3 read clears idle", 32'(idle_flag), 0);
        idle_bits(12);
        chk(idle_flag == 1'b0, "R9 no second idle flag", 32'(idle_flag), 0);
        send_byte(8'h3D);
        idle_bits(12);
        chk(idle_flag == 1'b1, "R9 idle after new frame", 32'(idle_flag), 1);
        pulse_rd;
    endtask

    task automatic t_idle_type;
        idle_type = 1'b0;
        send_byte(8'hFF);
        pulse_rd;
        wait_cyc(200);
        chk(idle_flag == 1'b1, "R10 early idle type0", 32'(idle_flag), 1);
        pulse_rd;
        idle_bits(12);
        idle_type = 1'b1;
        send_byte(8'hFF);
        pulse_rd;
        wait_cyc(200);
        chk(idle_flag == 1'b0, "R10 no early idle type1", 32'(idle_flag), 0);
        wait_cyc(600);
        chk(idle_flag == 1'b1, "R10 late idle type1", 32'(idle_flag), 1);
        pulse_rd;
    endtask

    task automatic t_idle_wake;
        wake_sel = 1'b0;
        idle_type = 1'b1;
        send_byte(8'h11);
        pulse_rd;
        pulse_sb;
        chk(standby == 1'b1, "R4 standby entered", 32'(standby), 1);
        send_byte(8'h22);
        chk(rdf == 1'b0, "R5 frame ignored", 32'(rdf), 0);
        chk(rx_data == 8'h11, "R5 data kept", 32'(rx_data), 32'h11);
        chk(standby == 1'b1, "R6 no wake by frame", 32'(standby), 1);
        idle_bits(12);
        chk(standby == 1'b0, "R6 idle wakes", 32'(standby), 0);
        chk(idle_flag == 1'b0, "R6 no idle flag", 32'(idle_flag), 0);
        chk(rdf == 1'b0, "R6 no rdf", 32'(rdf), 0);
    endtask

    task automatic t_addr_wake;
        wake_sel = 1'b1;
        idle_bits(2);
        pulse_rd;
        pulse_sb;
        chk(standby == 1'b1, "R4 standby addr mode", 32'(standby), 1);
        send_byte(8'h35);
        chk(rdf == 1'b0, "R8 msb0 no rdf", 32'(rdf), 0);
        chk(standby == 1'b1, "R8 msb0 no wake", 32'(standby), 1);
        chk(rx_data == 8'h11, "R5 data kept addr", 32'(rx_data), 32'h11);
        idle_bits(12);
        chk(standby == 1'b1, "R8 idle no wake", 32'(standby), 1);
        send_byte(8'hA5);
        chk(pre_sb == 1'b0, "R7 wake before stop", 32'(pre_sb), 0);
        chk(pre_rdf == 1'b0, "R7 rdf not before stop", 32'(pre_rdf), 0);
        chk(rdf == 1'b1, "R7 rdf set", 32'(rdf), 1);
        chk(rx_data == 8'hA5, "R7 address byte", 32'(rx_data), 32'hA5);
        pulse_rd;
    endtask

    task automatic t_immediate;
        wake_sel = 1'b0;
        idle_bits(12);
        pulse_rd;
        @(negedge clk);
        sb_set = 1'b1;
        @(negedge clk);
        sb_set = 1'b0;
        chk(standby == 1'b1, "R11 standby one cycle", 32'(standby), 1);
        @(negedge clk);
        chk(standby == 1'b0, "R11 immediate wake", 32'(standby), 0);
        chk(idle_flag == 1'b0, "R11 no idle flag", 32'(idle_flag), 0);
    endtask

    // Watchdog: a hung run counts as a failure.
    initial begin
        repeat (150000) @(posedge clk);
        if (!fin) begin
            total++;
            bad++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        t_reset;
        t_basic;
        t_glitch;
        t_idle_flag;
        t_idle_type;
        t_idle_wake;
        t_addr_wake;
        t_immediate;
        fin = 1'b1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule